// File: doc/BRIEF.md
# Two-Plane Command Pairing Unit

This unit sits between a per-chip command queue and that chip's interface sequencer. Single-page commands arrive one at a time on a valid/ready input stream. The unit keeps the oldest unsent command in a one-entry hold register and compares it with the command that follows it. If the two commands can share one array busy period, the unit sends them out together as one dual-plane command, so that two pages take the time of one. If they cannot, the held command leaves alone and the newcomer takes its place in the hold register. Commands are never reordered, except that the two halves of a pair are arranged by plane.

If no follower arrives, a held command does not wait forever. It is sent alone once the input has been idle for `HOLD_WAIT` cycles. The output is a registered valid/ready stream. While `out_valid` is high and `out_ready` is low, the output word stays frozen. While the output is stalled and a command sits in the hold register, `in_ready` is low, so the input stalls in turn. When the hold register is empty, `in_ready` is high whatever the state of the output.

Operation codes (`in_op`/`out_op`): 0 = page read, 1 = page program, 2 = block erase, 3 = reserved. Pairing only compares codes for equality, so any code can pair with itself.

Top module: `twoplane_pair`

## Requirements
- R1: A held command and the next accepted command are emitted as one word with `out_dual`=1 when all four of these hold: equal `op`, equal `die`, equal `page`, and block addresses whose bit 0 differs.
- R2: Two adjacent commands whose `op` codes differ are emitted as two single words (`out_dual`=0), in arrival order.
- R3: Two adjacent commands whose `page` values differ are emitted as two single words, in arrival order.
- R4: Two adjacent commands whose block addresses have equal bit 0 are emitted as two single words, in arrival order.
- R5: Two adjacent commands whose `die` values differ are emitted as two single words, in arrival order.
- R6: In a dual word, `out_blk0`/`out_tag0` carry the command whose block bit 0 is 0, and `out_blk1`/`out_tag1` carry the command whose block bit 0 is 1. This applies whichever of the two arrived first. `out_op`, `out_die` and `out_page` carry the shared values.
- R7: Outputs appear in arrival order. A command that fails to pair with the held command becomes the new held command, and it may still pair with the command after it. Each accepted command appears in exactly one output word.
- R8: A held command with no follower is emitted alone. With `out_ready` high and no input, it appears on `out_valid` exactly `HOLD_WAIT`+1 cycles after the clock edge that accepted it.
- R9: While `out_valid`=1 and `out_ready`=0, the output word does not change on the next cycle. While a command is held and the output is stalled, `in_ready` is 0.
- R10: After reset, `out_valid`=0 and `in_ready`=1.
- R11: A single word has `out_dual`=0 and `out_blk1`=0 and `out_tag1`=0. Its fields in slot 0 are copied from the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input command valid |
| in_ready | output | 1 | Input command accepted when high with in_valid |
| in_op | input | 2 | Operation code |
| in_die | input | DIE_W | Die select |
| in_blk | input | BLK_W | Block address; bit 0 selects the plane |
| in_page | input | PAGE_W | Page within block |
| in_tag | input | TAG_W | Host tag returned on completion |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the word when high with out_valid |
| out_dual | output | 1 | 1 = two-plane word, 0 = single |
| out_op | output | 2 | Operation code |
| out_die | output | DIE_W | Die select |
| out_page | output | PAGE_W | Page address (shared in a pair) |
| out_blk0 | output | BLK_W | Even-plane block, or the block of a single |
| out_tag0 | output | TAG_W | Tag of the slot-0 command |
| out_blk1 | output | BLK_W | Odd-plane block in a pair, else 0 |
| out_tag1 | output | TAG_W | Tag of the slot-1 command in a pair, else 0 |

## Verification
A wrong hold-register state becomes visible at the output within one or two words. A stale or lost held command shows up as a missing, duplicated or out-of-order tag when the next command arrives, or at the latest `HOLD_WAIT`+1 cycles into an idle gap. A wrong comparison result shows up in the very next word, either as a dual flag where two singles were due or as the reverse. Swapped plane slots show up in the same word. Back-pressure faults show up on the cycle after a stall begins, as an output word that changes or an input that is wrongly accepted.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;
endpackage

// File: rtl/tp_pair_rules.sv
// Eligibility of two adjacent commands for one two-plane operation.
module tp_pair_rules #(
  parameter int DIE_W  = 2,
  parameter int BLK_W  = 11,
  parameter int PAGE_W = 7
) (
  input  tp_pkg::op_e        a_op,
  input  logic [DIE_W-1:0]   a_die,
  input  logic [BLK_W-1:0]   a_blk,
  input  logic [PAGE_W-1:0]  a_page,
  input  tp_pkg::op_e        b_op,
  input  logic [DIE_W-1:0]   b_die,
  input  logic [BLK_W-1:0]   b_blk,
  input  logic [PAGE_W-1:0]  b_page,
  output logic               mergeable
);
  logic same_op, same_die, same_page, other_plane;

  always_comb begin
    same_op     = (a_op == b_op);
    same_die    = (a_die == b_die);
    same_page   = (a_page == b_page);
    other_plane = (a_blk[0] != b_blk[0]);
    mergeable   = same_op && same_die && same_page && other_plane;
  end
endmodule

// File: rtl/tp_pair_order.sv
// Puts the even-plane command in slot 0 and the odd-plane one in slot 1.
module tp_pair_order #(
  parameter int BLK_W = 11,
  parameter int TAG_W = 4
) (
  input  logic [BLK_W-1:0] a_blk,
  input  logic [TAG_W-1:0] a_tag,
  input  logic [BLK_W-1:0] b_blk,
  input  logic [TAG_W-1:0] b_tag,
  output logic [BLK_W-1:0] s0_blk,
  output logic [TAG_W-1:0] s0_tag,
  output logic [BLK_W-1:0] s1_blk,
  output logic [TAG_W-1:0] s1_tag
);
  always_comb begin
    if (a_blk[0]) begin
      s0_blk = b_blk;
      s0_tag = b_tag;
      s1_blk = a_blk;
      s1_tag = a_tag;
    end else begin
      s0_blk = a_blk;
      s0_tag = a_tag;
      s1_blk = b_blk;
      s1_tag = b_tag;
    end
  end
endmodule

// File: rtl/tp_hold_timer.sv
// Counts cycles a command has spent in the hold register; saturates at the limit.
module tp_hold_timer #(
  parameter int HOLD_WAIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expired
);
  localparam int WAIT_W = $clog2(HOLD_WAIT + 1) + 1;
  localparam logic [WAIT_W-1:0] LIMIT = WAIT_W'(HOLD_WAIT);

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= '0;
    end else if (tick && (cnt != LIMIT)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (cnt == LIMIT);
endmodule

// File: rtl/twoplane_pair.sv
module twoplane_pair #(
  parameter int DIE_W     = 2,
  parameter int BLK_W     = 11,
  parameter int PAGE_W    = 7,
  parameter int TAG_W     = 4,
  parameter int HOLD_WAIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [DIE_W-1:0]  in_die,
  input  logic [BLK_W-1:0]  in_blk,
  input  logic [PAGE_W-1:0] in_page,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_dual,
  output logic [1:0]        out_op,
  output logic [DIE_W-1:0]  out_die,
  output logic [PAGE_W-1:0] out_page,
  output logic [BLK_W-1:0]  out_blk0,
  output logic [TAG_W-1:0]  out_tag0,
  output logic [BLK_W-1:0]  out_blk1,
  output logic [TAG_W-1:0]  out_tag1
);
  import tp_pkg::*;

  // hold register
  logic              hold_valid;
  op_e               hold_op;
  logic [DIE_W-1:0]  hold_die;
  logic [BLK_W-1:0]  hold_blk;
  logic [PAGE_W-1:0] hold_page;
  logic [TAG_W-1:0]  hold_tag;

  op_e               new_op;
  logic              mergeable, expired;
  logic              out_free, do_pair, do_swap, do_flush, emit, load_in;
  logic [BLK_W-1:0]  s0_blk, s1_blk;
  logic [TAG_W-1:0]  s0_tag, s1_tag;

  assign new_op = op_e'(in_op);

  tp_pair_rules #(.DIE_W(DIE_W), .BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_rules (
    .a_op(hold_op), .a_die(hold_die), .a_blk(hold_blk), .a_page(hold_page),
    .b_op(new_op),  .b_die(in_die),   .b_blk(in_blk),   .b_page(in_page),
    .mergeable(mergeable)
  );

  tp_pair_order #(.BLK_W(BLK_W), .TAG_W(TAG_W)) u_order (
    .a_blk(hold_blk), .a_tag(hold_tag), .b_blk(in_blk), .b_tag(in_tag),
    .s0_blk(s0_blk), .s0_tag(s0_tag), .s1_blk(s1_blk), .s1_tag(s1_tag)
  );

  always_comb begin
    out_free = !out_valid || out_ready;
    do_pair  = hold_valid && in_valid && mergeable && out_free;
    do_swap  = hold_valid && in_valid && !mergeable && out_free;
    do_flush = hold_valid && !in_valid && expired && out_free;
    emit     = do_pair || do_swap || do_flush;
    in_ready = !hold_valid || out_free;
    load_in  = in_valid && in_ready && !do_pair;
  end

  tp_hold_timer #(.HOLD_WAIT(HOLD_WAIT)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(load_in), .tick(hold_valid && !emit),
    .expired(expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_op    <= OP_READ;
      hold_die   <= '0;
      hold_blk   <= '0;
      hold_page  <= '0;
      hold_tag   <= '0;
    end else if (load_in) begin
      hold_valid <= 1'b1;
      hold_op    <= new_op;
      hold_die   <= in_die;
      hold_blk   <= in_blk;
      hold_page  <= in_page;
      hold_tag   <= in_tag;
    end else if (emit) begin
      hold_valid <= 1'b0;
    end
  end

  // registered output stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dual  <= 1'b0;
      out_op    <= '0;
      out_die   <= '0;
      out_page  <= '0;
      out_blk0  <= '0;
      out_tag0  <= '0;
      out_blk1  <= '0;
      out_tag1  <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_dual  <= do_pair;
      out_op    <= hold_op;
      out_die   <= hold_die;
      out_page  <= hold_page;
      if (do_pair) begin
        out_blk0 <= s0_blk;
        out_tag0 <= s0_tag;
        out_blk1 <= s1_blk;
        out_tag1 <= s1_tag;
      end else begin
        out_blk0 <= hold_blk;
        out_tag0 <= hold_tag;
        out_blk1 <= '0;
        out_tag1 <= '0;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/twoplane_pair_chk.sv
module twoplane_pair_chk #(
  parameter int DIE_W     = 2,
  parameter int BLK_W     = 11,
  parameter int PAGE_W    = 7,
  parameter int TAG_W     = 4,
  parameter int HOLD_WAIT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_dual,
  input logic [1:0]        out_op,
  input logic [DIE_W-1:0]  out_die,
  input logic [PAGE_W-1:0] out_page,
  input logic [BLK_W-1:0]  out_blk0,
  input logic [TAG_W-1:0]  out_tag0,
  input logic [BLK_W-1:0]  out_blk1,
  input logic [TAG_W-1:0]  out_tag1
);
  localparam int IDLE_W = $clog2(HOLD_WAIT + 4) + 1;
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(HOLD_WAIT + 2);

  logic [2:0]        pending;
  logic [IDLE_W-1:0] idle_cnt;
  logic              in_fire, out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= '0;
      idle_cnt <= '0;
    end else begin
      pending <= pending + {2'b0, in_fire}
               - (out_fire ? (out_dual ? 3'd2 : 3'd1) : 3'd0);
      if ((pending != 3'd0) && !in_valid && out_ready && !out_fire) begin
        if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
      end else begin
        idle_cnt <= '0;
      end
    end
  end

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_dual, out_op, out_die, out_page, out_blk0, out_tag0, out_blk1, out_tag1}));

  a_r6_even_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_dual |-> !out_blk0[0] && out_blk1[0]);

  a_r11_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_dual |-> (out_blk1 == '0) && (out_tag1 == '0));

  a_r8_flush_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= IDLE_MAX);

  a_r7_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    pending <= 3'd3);

  a_r7_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> pending >= (out_dual ? 3'd2 : 3'd1));
endmodule

bind twoplane_pair twoplane_pair_chk #(
  .DIE_W(DIE_W), .BLK_W(BLK_W), .PAGE_W(PAGE_W), .TAG_W(TAG_W), .HOLD_WAIT(HOLD_WAIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_dual(out_dual),
  .out_op(out_op), .out_die(out_die), .out_page(out_page),
  .out_blk0(out_blk0), .out_tag0(out_tag0), .out_blk1(out_blk1), .out_tag1(out_tag1)
);

// File: tb/twoplane_pair_tb.sv
`timescale 1ns/1ps
module twoplane_pair_tb;
  localparam int DIE_W = 2, BLK_W = 11, PAGE_W = 7, TAG_W = 4, HOLD_WAIT = 4;

  typedef struct packed {
    logic [1:0]        op;
    logic [DIE_W-1:0]  die;
    logic [BLK_W-1:0]  blk;
    logic [PAGE_W-1:0] page;
    logic [TAG_W-1:0]  tag;
  } cmd_t;

  typedef struct packed {
    logic              dual;
    logic [1:0]        op;
    logic [DIE_W-1:0]  die;
    logic [PAGE_W-1:0] page;
    logic [BLK_W-1:0]  b0;
    logic [TAG_W-1:0]  t0;
    logic [BLK_W-1:0]  b1;
    logic [TAG_W-1:0]  t1;
  } word_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [1:0] in_op = '0;
  logic [DIE_W-1:0] in_die = '0;
  logic [BLK_W-1:0] in_blk = '0;
  logic [PAGE_W-1:0] in_page = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic out_dual;
  logic [1:0] out_op;
  logic [DIE_W-1:0] out_die;
  logic [PAGE_W-1:0] out_page;
  logic [BLK_W-1:0] out_blk0, out_blk1;
  logic [TAG_W-1:0] out_tag0, out_tag1;

  int checks = 0, errors = 0;
  int ready_mode = 1;  // 0 random, 1 high, 2 low
  word_t exp_q[$];
  string req_q[$];
  cmd_t  m_cmd;
  logic  m_valid = 1'b0;
  logic [TAG_W-1:0] next_tag = '0;

  always #4 clk = ~clk;

  twoplane_pair #(.DIE_W(DIE_W), .BLK_W(BLK_W), .PAGE_W(PAGE_W), .TAG_W(TAG_W),
                  .HOLD_WAIT(HOLD_WAIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_die(in_die), .in_blk(in_blk), .in_page(in_page), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_dual(out_dual), .out_op(out_op),
    .out_die(out_die), .out_page(out_page), .out_blk0(out_blk0), .out_tag0(out_tag0),
    .out_blk1(out_blk1), .out_tag1(out_tag1)
  );

  function automatic word_t mk_single(cmd_t c);
    word_t w;
    w = '{dual: 1'b0, op: c.op, die: c.die, page: c.page, b0: c.blk, t0: c.tag,
          b1: '0, t1: '0};
    return w;
  endfunction

  function automatic word_t mk_pair(cmd_t a, cmd_t b);
    word_t w;
    cmd_t e, o;
    e = a.blk[0] ? b : a;
    o = a.blk[0] ? a : b;
    w = '{dual: 1'b1, op: a.op, die: a.die, page: a.page, b0: e.blk, t0: e.tag,
          b1: o.blk, t1: o.tag};
    return w;
  endfunction

  function automatic logic can_pair(cmd_t a, cmd_t b);
    return (a.op == b.op) && (a.die == b.die) && (a.page == b.page) && (a.blk[0] != b.blk[0]);
  endfunction

  function automatic cmd_t mk_cmd(logic [1:0] op, logic [DIE_W-1:0] die,
                                  logic [BLK_W-1:0] blk, logic [PAGE_W-1:0] page);
    cmd_t c;
    c = '{op: op, die: die, blk: blk, page: page, tag: next_tag};
    next_tag = next_tag + 1'b1;
    return c;
  endfunction

  task automatic check(logic ok, string rq, string what, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  // driver-side reference model: pushes expected output words
  task automatic model(cmd_t c, string rq);
    if (m_valid && can_pair(m_cmd, c)) begin
      exp_q.push_back(mk_pair(m_cmd, c)); req_q.push_back(rq);
      m_valid = 1'b0;
    end else begin
      if (m_valid) begin
        exp_q.push_back(mk_single(m_cmd)); req_q.push_back(rq);
      end
      m_cmd = c;
      m_valid = 1'b1;
    end
  endtask

  task automatic drive(cmd_t c);
    in_valid = 1'b1;
    in_op = c.op; in_die = c.die; in_blk = c.blk; in_page = c.page; in_tag = c.tag;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
  endtask

  task automatic send(cmd_t c, string rq);
    model(c, rq);
    drive(c);
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    ready_mode = 1;
    if (m_valid) begin
      exp_q.push_back(mk_single(m_cmd)); req_q.push_back("R8");
      m_valid = 1'b0;
    end
    repeat (n) @(negedge clk);
  endtask

  // ready generator
  initial begin
    forever begin
      @(negedge clk); #0.5;
      case (ready_mode)
        0: out_ready = ($urandom % 4) != 0;
        1: out_ready = 1'b1;
        default: out_ready = 1'b0;
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    word_t got, prev;
    logic stalled;
    stalled = 1'b0;
    prev = '0;
    forever begin
      @(negedge clk); #2;
      got = '{dual: out_dual, op: out_op, die: out_die, page: out_page, b0: out_blk0,
              t0: out_tag0, b1: out_blk1, t1: out_tag1};
      if (rst_n) begin
        if (stalled)
          check(out_valid && (got == prev), "R9", "word changed under stall",
                64'(got), 64'(prev));
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected output word", 64'(got), 64'(0));
          end else begin
            word_t e;
            string rq;
            e = exp_q.pop_front();
            rq = req_q.pop_front();
            check(got == e, rq, "output word", 64'(got), 64'(e));
          end
        end
        stalled = out_valid && !out_ready;
        prev = got;
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cmd_t a, b, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'(1));
    check(out_valid == 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'(0));
    @(negedge clk);

    // R1: basic pair, even block first
    send(mk_cmd(2'd0, 2'd1, 11'd20, 7'd5), "R1");
    send(mk_cmd(2'd0, 2'd1, 11'd21, 7'd5), "R1");
    idle(12);
    // R6: odd block arrives first, pair is reordered by plane
    send(mk_cmd(2'd1, 2'd2, 11'd7, 7'd9), "R6");
    send(mk_cmd(2'd1, 2'd2, 11'd100, 7'd9), "R6");
    idle(12);
    // R2: op differs
    send(mk_cmd(2'd0, 2'd0, 11'd4, 7'd3), "R2");
    send(mk_cmd(2'd1, 2'd0, 11'd5, 7'd3), "R2");
    idle(12);
    // R3: page differs
    send(mk_cmd(2'd2, 2'd0, 11'd4, 7'd3), "R3");
    send(mk_cmd(2'd2, 2'd0, 11'd5, 7'd4), "R3");
    idle(12);
    // R4: same plane bit
    send(mk_cmd(2'd0, 2'd3, 11'd6, 7'd1), "R4");
    send(mk_cmd(2'd0, 2'd3, 11'd8, 7'd1), "R4");
    idle(12);
    // R5: die differs
    send(mk_cmd(2'd0, 2'd1, 11'd2, 7'd1), "R5");
    send(mk_cmd(2'd0, 2'd2, 11'd3, 7'd1), "R5");
    idle(12);
    // R7: unpaired newcomer becomes head and pairs with the following command
    send(mk_cmd(2'd0, 2'd0, 11'd10, 7'd2), "R7");
    send(mk_cmd(2'd1, 2'd0, 11'd12, 7'd2), "R7");
    send(mk_cmd(2'd1, 2'd0, 11'd13, 7'd2), "R7");
    idle(12);

    // R8: exact flush latency of a lone command
    a = mk_cmd(2'd0, 2'd1, 11'd30, 7'd6);
    send(a, "R8");
    in_valid = 1'b0;
    exp_q.push_back(mk_single(a)); req_q.push_back("R8");
    m_valid = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int k = 1; k <= 12; k++) begin
        @(negedge clk); #2;
        if (out_valid && seen == 0) seen = k;
      end
      check(seen == HOLD_WAIT + 1, "R8", "flush latency", 64'(seen), 64'(HOLD_WAIT + 1));
    end
    idle(4);

    // R9: back-pressure blocks input while holding
    ready_mode = 2;
    @(negedge clk);
    a = mk_cmd(2'd0, 2'd0, 11'd40, 7'd8);
    b = mk_cmd(2'd0, 2'd1, 11'd41, 7'd8);
    c = mk_cmd(2'd0, 2'd1, 11'd42, 7'd8);
    send(a, "R9");
    send(b, "R9");
    model(c, "R9");
    in_valid = 1'b1;
    in_op = c.op; in_die = c.die; in_blk = c.blk; in_page = c.page; in_tag = c.tag;
    repeat (3) @(negedge clk);
    #1;
    check(in_ready == 1'b0, "R9", "in_ready under stall", 64'(in_ready), 64'(0));
    check(out_valid && out_tag0 == a.tag, "R9", "stalled word tag", 64'(out_tag0), 64'(a.tag));
    ready_mode = 1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    idle(12);

    // mixed stream with random back-pressure
    ready_mode = 0;
    for (int i = 0; i < 80; i++) begin
      send(mk_cmd(2'($urandom % 2), 2'($urandom % 2), 11'($urandom % 4), 7'($urandom % 2)),
           "R7");
    end
    idle(20);

    begin
      int waitn;
      waitn = 0;
      while (exp_q.size() != 0 && waitn < 100) begin
        @(negedge clk); waitn++;
      end
    end
    check(exp_q.size() == 0, "R7", "words left unseen", 64'(exp_q.size()), 64'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule